// File: doc/BRIEF.md
# SMBus Clock Control and Bus Timeout Monitor

This block sits beside an SMBus controller and owns two jobs. It generates the serial clock, and it watches the bus. A host sets a small control register. That register holds a held soft-reset bit, a clock-enable bit and a divide-by-two bit. From these settings the block drives SCLK low in a regular pattern at the full rate, at half rate, or not at all. SCLK is an open-drain output, so the block only ever pulls it low or releases it.

The block also watches the bus. It samples SCLK and SDA through a two-flop synchroniser. A sticky timeout error is raised when SCLK stays low beyond a configurable limit. The block reports the bus as idle once both lines have stayed high past a second limit. A halted clock held high is a legal idle bus and never counts as a timeout.

The host sees two registers on a one-bit address. Address 0 is control. Address 1 is status, where the timeout error is cleared by writing a 1. The rates and limits are parameters derived from the system clock frequency. The defaults are 100 kHz, 35 ms and 50 us.

Top module: `smb_clk_ctrl`

## Requirements
- R1: Control bit 7 is a soft reset that hardware never clears. While it is 1, SCLK is released, status bits 0 and 1 read 0, and the counters stay cleared. The control register keeps what was written to it, and it resets to 0x00.
- R2: In the control register only bits 7, 2 and 1 are stored. Bits 6 to 3 and bit 0 always read 0, and writes to them are ignored.
- R3: When control bit 1 (clock enable) is 0, SCLK is never driven low, whatever bit 2 holds.
- R4: With enable 1 and bit 2 (divide) 0, each low phase and each high phase of the generated SCLK lasts HALF_CYC system clocks. HALF_CYC is SYS_CLK_HZ / (2 * SCL_FAST_HZ).
- R5: With enable 1 and divide 1, each phase lasts 2 * HALF_CYC system clocks, which is half the rate.
- R6: Status bit 0 (timeout error) sets once synchronised SCLK has been low for TIMEOUT_CYC clocks. A low interval that is clearly shorter than this leaves the bit at 0.
- R7: The timeout error is sticky. Writing 1 to status bit 0 clears it, and writing 0 there leaves it unchanged.
- R8: Status bit 1 and output bus_idle go to 1 once synchronised SCLK and SDA have both been high for IDLE_CYC clocks. They read 0 while SCLK is toggling at a phase shorter than that.
- R9: A bus whose clock is stopped and held high never sets the timeout error, however long it stays that way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| scl_in | input | 1 | Sampled SCLK bus line |
| sda_in | input | 1 | Sampled SDA bus line |
| scl_oe | output | 1 | 1 pulls SCLK low, 0 releases it |
| bus_idle | output | 1 | Both lines high for longer than the idle limit |

## Verification
The properties assume that the register port changes between clock edges. They also assume that scl_in and sda_in are arbitrary asynchronous levels, since all timing checks look only at the synchronised copies. The stimulus models the SCLK line as a wired-AND of the block's own drive and a second device that can hold the line low. The bench holds that external low for intervals placed well inside or well outside the timeout limit. This keeps the outcome independent of the synchroniser's few cycles of latency. All register accesses are issued on the falling clock edge.

// File: rtl/smbclk_pkg.sv
package smbclk_pkg;
  localparam logic       ADDR_CTRL    = 1'b0;
  localparam logic       ADDR_STAT    = 1'b1;
  localparam int         CTRL_SRST    = 7;
  localparam int         CTRL_DIV     = 2;
  localparam int         CTRL_EN      = 1;
  localparam logic [7:0] CTRL_WMASK   = 8'h86;
  localparam int         STAT_TE      = 0;
  localparam int         STAT_IDLE    = 1;
endpackage

// File: rtl/smbclk_sync.sv
module smbclk_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= din[g];
        s2_q <= s1_q;
      end
    end
    assign dout[g] = s2_q;
  end
endmodule

// File: rtl/smbclk_regs.sv
module smbclk_regs
  import smbclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       te_hit,
  input  logic       idle,
  output logic [7:0] ctrl,
  output logic       te,
  output logic [7:0] rdata
);
  logic [7:0] ctrl_q, ctrl_d;
  logic       te_q, te_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we && addr == ADDR_CTRL) ctrl_d = wdata & CTRL_WMASK;
  end

  always_comb begin
    te_d = te_q;
    if (ctrl_q[CTRL_SRST])                          te_d = 1'b0;
    else if (te_hit)                                te_d = 1'b1;
    else if (we && addr == ADDR_STAT && wdata[STAT_TE]) te_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
      te_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      te_q   <= te_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == ADDR_CTRL) begin
      rdata = ctrl_q;
    end else begin
      rdata[STAT_TE]   = te_q;
      rdata[STAT_IDLE] = idle;
    end
  end

  assign ctrl = ctrl_q;
  assign te   = te_q;
endmodule

// File: rtl/smbclk_gen.sv
module smbclk_gen #(
  parameter int HALF_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic div2,
  output logic scl_drive
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pre_q, pre_d;
  logic          ph_q, ph_d;
  logic          run, tick;

  assign run  = en && !clr;
  assign tick = div2 ? pre_q : 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    pre_d = pre_q;
    ph_d  = ph_q;
    if (!run) begin
      cnt_d = '0;
      pre_d = 1'b0;
      ph_d  = 1'b0;
    end else begin
      pre_d = div2 ? ~pre_q : 1'b0;
      if (tick) begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          ph_d  = ~ph_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      ph_q  <= ph_d;
    end
  end

  assign scl_drive = ph_q;
endmodule

// File: rtl/smbclk_mon.sv
module smbclk_mon #(
  parameter int TIMEOUT_CYC = 3500000,
  parameter int IDLE_CYC    = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scl_s,
  input  logic sda_s,
  output logic te_hit,
  output logic bus_idle
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam logic [TW-1:0] TO_MAX  = TW'(TIMEOUT_CYC);
  localparam logic [TW-1:0] TO_EDGE = TW'(TIMEOUT_CYC - 1);
  localparam logic [IW-1:0] ID_MAX  = IW'(IDLE_CYC);

  logic [TW-1:0] low_q, low_d;
  logic [IW-1:0] hi_q, hi_d;

  always_comb begin
    low_d = low_q;
    if (clr || scl_s)      low_d = '0;
    else if (low_q != TO_MAX) low_d = low_q + 1'b1;
  end

  always_comb begin
    hi_d = hi_q;
    if (clr || !(scl_s && sda_s)) hi_d = '0;
    else if (hi_q != ID_MAX)      hi_d = hi_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      hi_q  <= '0;
    end else begin
      low_q <= low_d;
      hi_q  <= hi_d;
    end
  end

  assign te_hit   = !clr && !scl_s && (low_q == TO_EDGE);
  assign bus_idle = (hi_q == ID_MAX);
endmodule

// File: rtl/smb_clk_ctrl.sv
module smb_clk_ctrl
  import smbclk_pkg::*;
#(
  parameter int SYS_CLK_HZ  = 100000000,
  parameter int SCL_FAST_HZ = 100000,
  parameter int TIMEOUT_US  = 35000,
  parameter int IDLE_US     = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       bus_idle
);
  localparam int HALF_CYC    = SYS_CLK_HZ / (2 * SCL_FAST_HZ);
  localparam int CYC_PER_US  = SYS_CLK_HZ / 1000000;
  localparam int TIMEOUT_CYC = CYC_PER_US * TIMEOUT_US;
  localparam int IDLE_CYC    = CYC_PER_US * IDLE_US;

  logic       rs1_q, rs2_q, rst_ni;
  logic [7:0] ctrl;
  logic       srst, clk_en, div2;
  logic       te, te_hit, idle;
  logic [1:0] bus_s;
  logic       scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_ni = rs2_q;

  assign srst   = ctrl[CTRL_SRST];
  assign clk_en = ctrl[CTRL_EN];
  assign div2   = ctrl[CTRL_DIV];

  smbclk_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst_n (rst_ni),
    .din ({sda_in, scl_in}),
    .dout (bus_s)
  );
  assign scl_s = bus_s[0];
  assign sda_s = bus_s[1];

  smbclk_regs u_regs (
    .clk (clk),
    .rst_n (rst_ni),
    .we (reg_we),
    .addr (reg_addr),
    .wdata (reg_wdata),
    .te_hit (te_hit),
    .idle (idle),
    .ctrl (ctrl),
    .te (te),
    .rdata (reg_rdata)
  );

  smbclk_gen #(.HALF_CYC(HALF_CYC)) u_gen (
    .clk (clk),
    .rst_n (rst_ni),
    .clr (srst),
    .en (clk_en),
    .div2 (div2),
    .scl_drive (scl_oe)
  );

  smbclk_mon #(.TIMEOUT_CYC(TIMEOUT_CYC), .IDLE_CYC(IDLE_CYC)) u_mon (
    .clk (clk),
    .rst_n (rst_ni),
    .clr (srst),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .te_hit (te_hit),
    .bus_idle (idle)
  );

  assign bus_idle = idle;
endmodule

// File: rtl/smb_clk_ctrl_chk.sv
module smb_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic       reg_addr,
  input logic       wdata0,
  input logic [7:0] reg_rdata,
  input logic       scl_oe,
  input logic       bus_idle,
  input logic       srst,
  input logic       clk_en,
  input logic       te,
  input logic       scl_s,
  input logic       sda_s
);
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!scl_oe && !te && !bus_idle)); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> ((reg_rdata & 8'h79) == 8'h00)); // R2

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !scl_oe); // R3

  AST_TE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te) |-> !$past(scl_s)); // R6

  AST_TE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (te && !srst && !(reg_we && reg_addr && wdata0)) |=> te); // R7

  AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_idle) |-> $past(scl_s && sda_s)); // R8
endmodule

bind smb_clk_ctrl smb_clk_ctrl_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .reg_we (reg_we),
  .reg_addr (reg_addr),
  .wdata0 (reg_wdata[0]),
  .reg_rdata (reg_rdata),
  .scl_oe (scl_oe),
  .bus_idle (bus_idle),
  .srst (srst),
  .clk_en (clk_en),
  .te (te),
  .scl_s (scl_s),
  .sda_s (sda_s)
);

// File: tb/test_smb_clk_ctrl.sv
`timescale 1ns/1ps
module test_smb_clk_ctrl;
  localparam int HALF = 5;
  localparam int TO   = 200;
  localparam int IDL  = 20;

  typedef struct {
    logic       addr;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       scl_oe;
  logic       bus_idle;
  logic       ext_low;
  logic       sda_line;
  logic       scl_line;

  int n_cmp;
  int n_bad;
  bit done;
  sb_item_t sb_q[$];

  assign scl_line = !scl_oe && !ext_low;

  smb_clk_ctrl #(
    .SYS_CLK_HZ(1000000), .SCL_FAST_HZ(100000), .TIMEOUT_US(TO), .IDLE_US(IDL)
  ) i_smb_clk_ctrl (
    .clk (clk),
    .rst_n (rst_n),
    .reg_we (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .scl_in (scl_line),
    .sda_in (sda_line),
    .scl_oe (scl_oe),
    .bus_idle (bus_idle)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected register values and compares what the design returns
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(reg_rdata === it.exp, it.tag, int'(reg_rdata), int'(it.exp));
      end
    end
  end

  task automatic expect_reg(input logic a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    reg_addr = a;
    it.addr = a;
    it.exp  = e;
    it.tag  = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_low(input int n);
    @(negedge clk);
    ext_low = 1'b1;
    repeat (n) @(negedge clk);
    ext_low = 1'b0;
  endtask

  task automatic measure(input int exp_len, input string tag);
    int lo;
    int hi;
    int guard;
    guard = 0;
    while (scl_oe !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
    while (scl_oe !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    lo = 0;
    while (scl_oe === 1'b1 && lo < 100) begin lo++; @(negedge clk); end
    hi = 0;
    while (scl_oe === 1'b0 && hi < 100) begin hi++; @(negedge clk); end
    check(lo == exp_len, {tag, " low phase"}, lo, exp_len);
    check(hi == exp_len, {tag, " high phase"}, hi, exp_len);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
    ext_low = 1'b0; sda_line = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    expect_reg(1'b0, 8'h00, "R1 control reset value");
    expect_reg(1'b1, 8'h00, "R1 status reset value");
    check(scl_oe === 1'b0, "R3 scl released after reset", int'(scl_oe), 0);
    idle_cycles(IDL + 10);
    expect_reg(1'b1, 8'h02, "R8 idle with both lines high");

    // short low: no timeout
    hold_low(TO - 30);
    idle_cycles(5);
    expect_reg(1'b1, 8'h00, "R6 short low leaves TE clear");
    // long low: timeout
    hold_low(TO + 30);
    idle_cycles(5);
    expect_reg(1'b1, 8'h01, "R6 long low sets TE");
    wr(1'b1, 8'h00);
    expect_reg(1'b1, 8'h01, "R7 write 0 keeps TE");
    idle_cycles(IDL + 10);
    expect_reg(1'b1, 8'h03, "R7 TE stays with idle bus");
    wr(1'b1, 8'h01);
    expect_reg(1'b1, 8'h02, "R7 write 1 clears TE");

    // soft reset
    hold_low(TO + 30);
    idle_cycles(5);
    expect_reg(1'b1, 8'h01, "R6 TE set before soft reset");
    wr(1'b0, 8'h86);
    expect_reg(1'b0, 8'h86, "R1 control keeps value under soft reset");
    expect_reg(1'b1, 8'h00, "R1 soft reset clears status");
    idle_cycles(IDL + 20);
    check(scl_oe === 1'b0, "R1 scl released under soft reset", int'(scl_oe), 0);
    expect_reg(1'b1, 8'h00, "R1 counters held under soft reset");

    // half rate, then full rate
    wr(1'b0, 8'h06);
    measure(2 * HALF, "R5 divided clock");
    wr(1'b0, 8'h02);
    measure(HALF, "R4 full rate clock");
    idle_cycles(IDL + 10);
    expect_reg(1'b1, 8'h00, "R8 no idle while clock toggles");

    // reserved bits, enable off with divide set
    wr(1'b0, 8'h7D);
    expect_reg(1'b0, 8'h04, "R2 reserved bits read zero");
    begin
      int seen;
      seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (scl_oe !== 1'b0) seen++;
      end
      check(seen == 0, "R3 no drive with enable 0", seen, 0);
    end

    // stopped clock held high for long
    idle_cycles(TO + 60);
    expect_reg(1'b1, 8'h02, "R9 stopped high clock gives idle, no TE");

    finish_run();
  end
endmodule